// File: doc/BRIEF.md
# Prioritized Video Source Change-over Controller

The controller decides which video source feeds the output. It looks at the present and lock status flags of an electrical input and an optical input, and it works through a priority list of up to three entries. Each entry names a physical input, the internal generator, mute, or nothing. A millisecond tick drives two timers. The hold timer keeps a failed source on air for a set time before the controller falls back to a lower-priority entry. The stability timer makes a recovered input prove itself for a set time before the controller returns to it.

The trigger rule selects what counts as a failure: the loss of the signal, or the loss of lock. Latching stops the controller from climbing back up the list once it has fallen back. Latching can be switched on only under the loss-of-signal rule, and the loss-of-lock rule turns it on by force. Even when latched, the controller always leaves the generator or mute for a physical input that has recovered. A latch-clear pulse makes the controller search the list again from the top.

In manual mode a single chosen source acts as a one-entry list. The outputs are the code of the selected source and the priority level it occupies. The switching of the video datapath itself is outside this block.

Top module: `vsrc_failover`

## Requirements
- R1: When reset is applied, the level returns to 0, and both timers clear. `sel_src` then shows the code of the level-0 entry.
- R2: The source codes are 0 = electrical, 1 = optical, 2 = generator, 3 = mute and 4 = none. A list entry holding a code of 4 or more is unused and is skipped when falling back. `sel_src` is the code of the entry at `sel_level`, and `sel_level` never exceeds 2.
- R3: With `auto_mode` low, the list is `manual_src` at level 0 and nothing at levels 1 and 2. The automatic list entries are ignored.
- R4: Under the loss-of-signal rule (`rule_lol` = 0), a physical input is healthy while its present flag is high. Under the loss-of-lock rule, it needs both its present flag and its lock flag. The generator and mute are always healthy, so the controller never falls back away from them.
- R5: Suppose the selected entry stays unhealthy through `hold_ms` ticks. On the next clock edge, the controller moves to the first healthy entry below it. With `hold_ms` = 0, the move happens on the first edge at which the entry is unhealthy.
- R6: When not latched, the controller returns to the highest-priority entry that qualifies. A physical input qualifies once it has stayed healthy through `lock_ms` ticks. The generator and mute qualify at once. A higher entry that is healthy but not yet qualified is not selected.
- R7: The controller is latched while `latch_en` or `rule_lol` is high. While latched and on a physical source, it never moves to a higher-priority level. While latched and on the generator or mute, it moves up to a qualified physical entry.
- R8: A pulse on `latch_clr` selects the first qualified entry from the top of the list. If no entry qualifies, it selects the lowest listed entry.
- R9: When a fallback is due and no entry below the current one is healthy, the controller holds the lowest listed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond |
| elec_present | input | 1 | Electrical input carries a signal |
| elec_locked | input | 1 | Electrical input is locked |
| opt_present | input | 1 | Optical input carries a signal |
| opt_locked | input | 1 | Optical input is locked |
| auto_mode | input | 1 | 1 = priority list, 0 = manual single source |
| manual_src | input | 3 | Source code used in manual mode |
| prio_main | input | 3 | Source code at level 0 |
| prio_bk1 | input | 3 | Source code at level 1 |
| prio_bk2 | input | 3 | Source code at level 2 |
| rule_lol | input | 1 | 1 = loss of lock, 0 = loss of signal |
| latch_en | input | 1 | Latching under the loss-of-signal rule |
| latch_clr | input | 1 | Pulse to re-evaluate the list from the top |
| hold_ms | input | TIME_W | Hold time in ticks |
| lock_ms | input | TIME_W | Recovery time in ticks |
| sel_src | output | 3 | Code of the selected source |
| sel_level | output | 2 | Priority level of the selected source |

## Verification
The bench checks the hold boundary exactly: one tick short of `hold_ms` must keep the failing source, and the final tick must switch it. A design with an off-by-one error would change over early or late. The bench also stops a returning input one tick short of `lock_ms`, which catches a design that returns before the input is stable. It checks that an input that is present but unlocked counts as healthy under one rule and as failed under the other, so a design that ignores the rule selection is caught. It then walks the latched cases: no climbing back from a physical source, the forced exit from the generator, and a clear pulse. A design with the latch inverted, or with the generator exception missing, would either climb back or stay on the generator. Finally, it covers unused list entries being skipped, the mute source being treated as healthy, the case where every listed input is dead, and manual mode. A design that got these wrong would select none, leave mute, or jump to an entry that is not listed.

// File: rtl/vsrc_failover_pkg.sv
package vsrc_failover_pkg;

    localparam int NUM_LEVELS = 3;
    localparam int LVL_W      = 2;
    localparam int NUM_PHYS   = 2;

    typedef logic [2:0] src_code_t;

    localparam src_code_t SRC_ELEC = 3'd0;
    localparam src_code_t SRC_OPT  = 3'd1;
    localparam src_code_t SRC_GEN  = 3'd2;
    localparam src_code_t SRC_MUTE = 3'd3;
    localparam src_code_t SRC_NONE = 3'd4;

    typedef struct packed {
        logic listed;
        logic phys;
        logic ok;
        logic qual;
    } lvl_info_t;

    function automatic logic code_listed(input src_code_t c);
        return c < SRC_NONE;
    endfunction

    function automatic logic code_phys(input src_code_t c);
        return c <= SRC_OPT;
    endfunction

    function automatic logic code_soft(input src_code_t c);
        return (c == SRC_GEN) || (c == SRC_MUTE);
    endfunction

endpackage

// File: rtl/vsf_stab_timer.sv
module vsf_stab_timer
    import vsrc_failover_pkg::*;
#(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              healthy,
    input  logic [TIME_W-1:0] lock_ms,
    output logic              qualified
);
    localparam logic [TIME_W-1:0] CNT_MAX = '1;

    logic [TIME_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !healthy) begin
            cnt <= '0;
        end else if (tick && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qualified = healthy && (cnt >= lock_ms);
endmodule

// File: rtl/vsf_hold_timer.sv
module vsf_hold_timer
    import vsrc_failover_pkg::*;
#(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              failing,
    input  logic              restart,
    input  logic [TIME_W-1:0] hold_ms,
    output logic              expired
);
    localparam logic [TIME_W-1:0] CNT_MAX = '1;

    logic [TIME_W-1:0] miss;

    always_ff @(posedge clk) begin
        if (rst || restart || !failing) begin
            miss <= '0;
        end else if (tick && miss != CNT_MAX) begin
            miss <= miss + 1'b1;
        end
    end

    assign expired = failing && (miss >= hold_ms);
endmodule

// File: rtl/vsf_level_sel.sv
module vsf_level_sel
    import vsrc_failover_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lvl_info_t        info [NUM_LEVELS],
    input  logic             latched,
    input  logic             latch_clr,
    input  logic             hold_expired,
    output logic [LVL_W-1:0] level,
    output logic             level_move
);
    logic [LVL_W-1:0] nxt, below_idx, lowest_idx, rec_idx, top_idx;
    logic             below_found, rec_found, top_found;
    logic             cur_ok, cur_phys;

    always_comb begin
        cur_ok     = info[level].ok;
        cur_phys   = info[level].phys;
        below_found = 1'b0;
        below_idx   = '0;
        rec_found   = 1'b0;
        rec_idx     = '0;
        top_found   = 1'b0;
        top_idx     = '0;
        lowest_idx  = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (info[i].listed) lowest_idx = LVL_W'(i);
        end
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (i > int'(level) && info[i].ok) begin
                below_found = 1'b1;
                below_idx   = LVL_W'(i);
            end
            if (i < int'(level) && info[i].qual &&
                (!latched || (!cur_phys && info[i].phys))) begin
                rec_found = 1'b1;
                rec_idx   = LVL_W'(i);
            end
            if (info[i].qual) begin
                top_found = 1'b1;
                top_idx   = LVL_W'(i);
            end
        end

        if (latch_clr) begin
            nxt = top_found ? top_idx : lowest_idx;
        end else if (rec_found) begin
            nxt = rec_idx;
        end else if (!cur_ok && hold_expired) begin
            nxt = below_found ? below_idx : lowest_idx;
        end else begin
            nxt = level;
        end
    end

    assign level_move = (nxt != level);

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= nxt;
    end
endmodule

// File: rtl/vsrc_failover.sv
module vsrc_failover
    import vsrc_failover_pkg::*;
#(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1ms,
    input  logic              elec_present,
    input  logic              elec_locked,
    input  logic              opt_present,
    input  logic              opt_locked,
    input  logic              auto_mode,
    input  logic [2:0]        manual_src,
    input  logic [2:0]        prio_main,
    input  logic [2:0]        prio_bk1,
    input  logic [2:0]        prio_bk2,
    input  logic              rule_lol,
    input  logic              latch_en,
    input  logic              latch_clr,
    input  logic [TIME_W-1:0] hold_ms,
    input  logic [TIME_W-1:0] lock_ms,
    output logic [2:0]        sel_src,
    output logic [1:0]        sel_level
);
    src_code_t        list [NUM_LEVELS];
    lvl_info_t        info [NUM_LEVELS];
    logic [NUM_PHYS-1:0] phys_ok, phys_qual;
    logic [NUM_PHYS-1:0] pres, lck;
    logic [LVL_W-1:0] level;
    logic             level_move, hold_expired, latched;

    assign pres    = {opt_present, elec_present};
    assign lck     = {opt_locked,  elec_locked};
    assign latched = latch_en || rule_lol;

    always_comb begin
        list[0] = auto_mode ? prio_main : manual_src;
        list[1] = auto_mode ? prio_bk1  : SRC_NONE;
        list[2] = auto_mode ? prio_bk2  : SRC_NONE;
    end

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
        assign phys_ok[p] = pres[p] && (lck[p] || !rule_lol);
        vsf_stab_timer #(.TIME_W(TIME_W)) u_stab (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_1ms),
            .healthy   (phys_ok[p]),
            .lock_ms   (lock_ms),
            .qualified (phys_qual[p])
        );
    end

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        always_comb begin
            info[l].listed = code_listed(list[l]);
            info[l].phys   = code_phys(list[l]);
            if (code_phys(list[l])) begin
                info[l].ok   = phys_ok[list[l][0]];
                info[l].qual = phys_qual[list[l][0]];
            end else begin
                info[l].ok   = code_soft(list[l]);
                info[l].qual = code_soft(list[l]);
            end
        end
    end

    vsf_hold_timer #(.TIME_W(TIME_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .failing (!info[level].ok),
        .restart (level_move),
        .hold_ms (hold_ms),
        .expired (hold_expired)
    );

    vsf_level_sel u_sel (
        .clk          (clk),
        .rst          (rst),
        .info         (info),
        .latched      (latched),
        .latch_clr    (latch_clr),
        .hold_expired (hold_expired),
        .level        (level),
        .level_move   (level_move)
    );

    assign sel_src   = list[level];
    assign sel_level = level;
endmodule

// File: rtl/vsf_checker.sv
module vsf_checker (
    input logic       clk,
    input logic       rst,
    input logic       auto_mode,
    input logic [2:0] manual_src,
    input logic [2:0] prio_main,
    input logic       rule_lol,
    input logic       latch_en,
    input logic       latch_clr,
    input logic [2:0] sel_src,
    input logic [1:0] sel_level
);
    logic [2:0] top_code;
    assign top_code = auto_mode ? prio_main : manual_src;

    assert_level_range_R2: assert property (@(posedge clk) disable iff (rst)
        sel_level <= 2'd2);

    assert_soft_never_left_R4: assert property (@(posedge clk) disable iff (rst)
        ((sel_src == 3'd2 || sel_src == 3'd3) && !latch_clr)
        |=> sel_level <= $past(sel_level));

    assert_latched_no_climb_R7: assert property (@(posedge clk) disable iff (rst)
        ((latch_en || rule_lol) && !latch_clr && sel_src <= 3'd1)
        |=> sel_level >= $past(sel_level));

    assert_clear_to_top_R8: assert property (@(posedge clk) disable iff (rst)
        (latch_clr && (top_code == 3'd2 || top_code == 3'd3))
        |=> sel_level == 2'd0);
endmodule

bind vsrc_failover vsf_checker u_vsf_chk (
    .clk        (clk),
    .rst        (rst),
    .auto_mode  (auto_mode),
    .manual_src (manual_src),
    .prio_main  (prio_main),
    .rule_lol   (rule_lol),
    .latch_en   (latch_en),
    .latch_clr  (latch_clr),
    .sel_src    (sel_src),
    .sel_level  (sel_level)
);

// File: tb/sim_vsrc_failover.sv
module sim_vsrc_failover;
    localparam int TIME_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic elec_present = 1'b1, elec_locked = 1'b1;
    logic opt_present = 1'b1, opt_locked = 1'b1;
    logic auto_mode = 1'b1;
    logic [2:0] manual_src = 3'd0;
    logic [2:0] prio_main = 3'd0, prio_bk1 = 3'd1, prio_bk2 = 3'd2;
    logic rule_lol = 1'b0, latch_en = 1'b0, latch_clr = 1'b0;
    logic [TIME_W-1:0] hold_ms = 12'd3, lock_ms = 12'd2;
    logic [2:0] sel_src;
    logic [1:0] sel_level;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    vsrc_failover #(.TIME_W(TIME_W)) u0 (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms),
        .elec_present(elec_present), .elec_locked(elec_locked),
        .opt_present(opt_present), .opt_locked(opt_locked),
        .auto_mode(auto_mode), .manual_src(manual_src),
        .prio_main(prio_main), .prio_bk1(prio_bk1), .prio_bk2(prio_bk2),
        .rule_lol(rule_lol), .latch_en(latch_en), .latch_clr(latch_clr),
        .hold_ms(hold_ms), .lock_ms(lock_ms),
        .sel_src(sel_src), .sel_level(sel_level)
    );

    // fields: [16:13] {e_pres,e_lock,o_pres,o_lock} [12:9] ticks
    //         [8:6] expected src [5:4] expected level [3:0] requirement
    // list: elec, opt, gen; loss of signal; no latch; hold 3; lock 2
    localparam logic [16:0] TBL [10] = '{
        {4'b1111, 4'd3, 3'd0, 2'd0, 4'd2},  // R2 stays on main
        {4'b0011, 4'd2, 3'd0, 2'd0, 4'd5},  // R5 one tick short of hold
        {4'b0011, 4'd1, 3'd1, 2'd1, 4'd5},  // R5 hold reached
        {4'b1111, 4'd1, 3'd1, 2'd1, 4'd6},  // R6 not yet stable
        {4'b1111, 4'd1, 3'd0, 2'd0, 4'd6},  // R6 return after lock time
        {4'b0000, 4'd3, 3'd2, 2'd2, 4'd5},  // R5 skips dead optical
        {4'b0011, 4'd1, 3'd2, 2'd2, 4'd6},  // R6 optical not yet stable
        {4'b0011, 4'd1, 3'd1, 2'd1, 4'd6},  // R6 optical qualifies
        {4'b1111, 4'd2, 3'd0, 2'd0, 4'd6},  // R6 back to main
        {4'b1011, 4'd3, 3'd0, 2'd0, 4'd4}   // R4 unlocked ok under loss of signal
    };

    task automatic check(input string tag, input logic [2:0] es, input logic [1:0] el);
        nchk++;
        if (sel_src !== es || sel_level !== el) begin
            nfail++;
            $display("FAIL %s: src=%0d level=%0d expected src=%0d level=%0d",
                     tag, sel_src, sel_level, es, el);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_1ms = 1'b1;
            @(negedge clk) tick_1ms = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_in(input logic [3:0] s);
        {elec_present, elec_locked, opt_present, opt_locked} = s;
    endtask

    initial begin
        #4_000_000;
        nfail++;
        $display("FAIL watchdog: run hung");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 3'd0, 2'd0);

        for (int v = 0; v < 10; v++) begin
            set_in(TBL[v][16:13]);
            @(negedge clk);
            ticks(int'(TBL[v][12:9]));
            check($sformatf("R%0d vector %0d", TBL[v][3:0], v), TBL[v][8:6], TBL[v][5:4]);
        end

        // R4 loss of lock rule, R7 forced latch, R8 latch clear
        rule_lol = 1'b1;
        set_in(4'b1111);
        do_reset();
        ticks(2);
        set_in(4'b1011);
        ticks(3);
        check("R4 unlocked fails under loss of lock", 3'd1, 2'd1);
        set_in(4'b1111);
        ticks(3);
        check("R7 loss of lock forces latch", 3'd1, 2'd1);
        @(negedge clk) latch_clr = 1'b1;
        @(negedge clk) latch_clr = 1'b0;
        check("R8 latch clear returns to top", 3'd0, 2'd0);
        rule_lol = 1'b0;

        // R7 latched under loss of signal, generator exception
        latch_en = 1'b1;
        set_in(4'b0000);
        do_reset();
        ticks(3);
        check("R7 both lost falls to generator", 3'd2, 2'd2);
        set_in(4'b0011);
        ticks(2);
        check("R7 leaves generator for optical", 3'd1, 2'd1);
        set_in(4'b1111);
        ticks(3);
        check("R7 no climb to electrical while latched", 3'd1, 2'd1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset to level 0", 3'd0, 2'd0);
        latch_en = 1'b0;

        // R2 unused entry skipped, R5 zero hold time
        prio_bk1 = 3'd4;
        hold_ms  = 12'd0;
        set_in(4'b1111);
        do_reset();
        set_in(4'b0011);
        repeat (2) @(negedge clk);
        check("R5 zero hold, R2 none skipped", 3'd2, 2'd2);
        hold_ms = 12'd3;

        // R4 mute always healthy
        prio_bk1 = 3'd3;
        prio_bk2 = 3'd4;
        set_in(4'b1111);
        do_reset();
        set_in(4'b0011);
        ticks(3);
        check("R4 mute selected as healthy", 3'd3, 2'd1);

        // R9 nothing healthy holds the lowest listed entry
        prio_bk1 = 3'd1;
        set_in(4'b1111);
        do_reset();
        set_in(4'b0000);
        ticks(3);
        check("R9 lowest listed held", 3'd1, 2'd1);

        // R3 manual mode single source
        auto_mode  = 1'b0;
        manual_src = 3'd1;
        set_in(4'b1111);
        do_reset();
        check("R3 manual source selected", 3'd1, 2'd0);
        set_in(4'b1100);
        ticks(3);
        check("R3 manual keeps its only entry", 3'd1, 2'd0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule